// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a raster display from timing values loaded through a small register write port. It runs on the pixel clock, keeps a pixel counter and a line counter, and decodes from them the horizontal and vertical sync strobes, a combined blanking strobe, a display-enable strobe and a frame-start marker. The host programs active size, total size and the blank and sync windows of both axes. Every value is a position or a count minus one, at single-pixel and single-line granularity.

It supports progressive and interlaced scan. In interlaced scan a field bit alternates every frame and the vertical sync of the odd field starts and ends half a line late. A panel-height register allows an image shorter than the panel to be centred: the vertical blank and sync lines move up by half the height difference. A combinational flag reports timing that breaks the sync-width, sync-spacing, size or interlace-parity rules. New register values wait in a pending copy and are applied only at the frame boundary.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter `hcnt` counts 0 up to the horizontal total field and then returns to 0. The line counter `vcnt` advances by one whenever `hcnt` returns to 0, and returns to 0 after the line equal to the vertical total field. Reset clears both counters.
- R2: `frame_start` is high exactly when `hcnt` and `vcnt` are both 0.
- R3: `de` is high exactly when `hcnt` is at or below the horizontal active field and `vcnt` is at or below the vertical active field.
- R4: `blank` is high when `hcnt` lies in the range (hblank start, hblank end], or when `vcnt` lies in the range (centred vblank start, centred vblank end].
- R5: `hsync` is high exactly when `hcnt` lies in the range (hsync start, hsync end]. The start field may hold any pixel position.
- R6: In progressive scan and in the even field, `vsync` is high for every pixel of the lines in (centred vsync start, centred vsync end].
- R7: With interlace enabled, `field` inverts at every frame wrap; with it disabled, `field` becomes 0 at the frame wrap. In the odd field (`field`=1 with interlace on), the vsync start and end points are both delayed by floor((horizontal total field + 1)/2) pixels into their lines.
- R8: The centring offset is floor((panel field − vertical active field)/2) when the panel field is larger, and 0 otherwise. It is subtracted from the vblank start, vblank end, vsync start and vsync end fields.
- R9: `cfg_invalid` is high when hsync end < hsync start + 8, or hsync start < hblank start + 8, or vertical active ≥ vertical total, or interlace is on and the vertical total field is odd or the vertical active field is even.
- R10: Writes update a pending copy. The applied timing takes the whole pending copy on the clock edge after which both counters are 0, so no frame mixes two settings.
- R11: Writes to bits outside the defined fields, and writes to address 7, have no effect on the outputs.
- R12: Register map, with the low field in bits [11:0] for horizontal registers and [10:0] otherwise, and the high field at bit 16 upward. Address 0 holds h active (low) and h total (high). Address 1 holds hblank start and end. Address 2 holds hsync start and end. Address 3 holds v active and v total. Address 4 holds vblank start and end. Address 5 holds vsync start and end. Address 6 holds panel height minus one (low) and the interlace enable in bit 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hcnt | output | 12 | Current pixel position in the line |
| vcnt | output | 11 | Current line in the frame |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Horizontal or vertical blanking |
| de | output | 1 | Display enable, active region |
| frame_start | output | 1 | First pixel of a frame |
| field | output | 1 | Interlace field, 1 = odd |
| cfg_invalid | output | 1 | Applied timing breaks a rule of R9 |

## Verification
The bench uses the package defaults: 12-bit pixel and 11-bit line fields. It programs small rasters of 50 pixels by 20 or 21 lines, so one run covers many frame wraps. These reach the deferred load with a write in the middle of a frame, a 25-pixel odd-field vsync shift, a centring offset of three lines, and an hsync one pixel too narrow. A behavioural model built from positions along the frame is compared with every output on every clock. This covers reserved-bit writes and writes to the unused address as well.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int HW        = 12;
  parameter int VW        = 11;
  parameter int DW        = 32;
  parameter int AW        = 3;
  parameter int HI_LSB    = 16;
  parameter int HSYNC_MIN = 8;
  parameter int HSYNC_GAP = 8;

  typedef enum logic [AW-1:0] {
    A_HSIZE  = 3'd0,
    A_HBLANK = 3'd1,
    A_HSYNC  = 3'd2,
    A_VSIZE  = 3'd3,
    A_VBLANK = 3'd4,
    A_VSYNC  = 3'd5,
    A_PANEL  = 3'd6
  } rtg_addr_e;

  typedef struct packed {
    logic [HW-1:0] h_act;
    logic [HW-1:0] h_tot;
    logic [HW-1:0] hb_s;
    logic [HW-1:0] hb_e;
    logic [HW-1:0] hs_s;
    logic [HW-1:0] hs_e;
    logic [VW-1:0] v_act;
    logic [VW-1:0] v_tot;
    logic [VW-1:0] vb_s;
    logic [VW-1:0] vb_e;
    logic [VW-1:0] vs_s;
    logic [VW-1:0] vs_e;
    logic [VW-1:0] panel;
    logic          il;
  } rtg_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load,
  output rtg_cfg_t      cfg_act
);
  rtg_cfg_t pend_q, pend_d, act_d;
  logic [HW-1:0] h_lo, h_hi;
  logic [VW-1:0] v_lo, v_hi;

  always_comb begin
    h_lo   = wr_data[HW-1:0];
    h_hi   = wr_data[HI_LSB +: HW];
    v_lo   = wr_data[VW-1:0];
    v_hi   = wr_data[HI_LSB +: VW];
    pend_d = pend_q;
    if (wr_en) begin
      case (wr_addr)
        A_HSIZE:  begin pend_d.h_act = h_lo; pend_d.h_tot = h_hi; end
        A_HBLANK: begin pend_d.hb_s  = h_lo; pend_d.hb_e  = h_hi; end
        A_HSYNC:  begin pend_d.hs_s  = h_lo; pend_d.hs_e  = h_hi; end
        A_VSIZE:  begin pend_d.v_act = v_lo; pend_d.v_tot = v_hi; end
        A_VBLANK: begin pend_d.vb_s  = v_lo; pend_d.vb_e  = v_hi; end
        A_VSYNC:  begin pend_d.vs_s  = v_lo; pend_d.vs_e  = v_hi; end
        A_PANEL:  begin pend_d.panel = v_lo; pend_d.il    = wr_data[HI_LSB]; end
        default:  ;
      endcase
    end
    act_d = load ? pend_q : cfg_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      cfg_act <= '0;
    end else begin
      pend_q  <= pend_d;
      cfg_act <= act_d;
    end
  end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  rtg_cfg_t      cfg,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          field,
  output logic          frame_end
);
  logic          line_end;
  logic [HW-1:0] hcnt_d;
  logic [VW-1:0] vcnt_d;
  logic          field_d;

  always_comb begin
    line_end  = (hcnt >= cfg.h_tot);
    frame_end = line_end && (vcnt >= cfg.v_tot);
    hcnt_d    = line_end ? '0 : hcnt + 1'b1;
    vcnt_d    = (vcnt >= cfg.v_tot) ? '0 : vcnt + 1'b1;
    field_d   = cfg.il ? ~field : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      vcnt  <= '0;
      field <= 1'b0;
    end else begin
      hcnt <= hcnt_d;
      if (line_end)  vcnt  <= vcnt_d;
      if (frame_end) field <= field_d;
    end
  end
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
(
  input  rtg_cfg_t      cfg,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          field,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          de,
  output logic          cfg_invalid
);
  localparam logic [HW:0] MIN_W = HSYNC_MIN[HW:0];
  localparam logic [HW:0] GAP_W = HSYNC_GAP[HW:0];
  localparam logic [HW:0] ONE_H = {{HW{1'b0}}, 1'b1};
  localparam logic [VW:0] ONE_V = {{VW{1'b0}}, 1'b1};

  logic [VW-1:0] adj, vbs_c, vbe_c, vss_c, vse_c;
  logic [HW:0]   half, shift, h_ext;
  logic [VW:0]   on_line, off_line, v_ext;
  logic          hblank, vblank, past_on, past_off;
  logic          bad_width, bad_gap, bad_size, bad_parity;

  always_comb begin
    adj   = (cfg.panel > cfg.v_act) ? ((cfg.panel - cfg.v_act) >> 1) : '0;
    vbs_c = cfg.vb_s - adj;
    vbe_c = cfg.vb_e - adj;
    vss_c = cfg.vs_s - adj;
    vse_c = cfg.vs_e - adj;

    hblank = (hcnt > cfg.hb_s) && (hcnt <= cfg.hb_e);
    vblank = (vcnt > vbs_c) && (vcnt <= vbe_c);
    blank  = hblank || vblank;
    hsync  = (hcnt > cfg.hs_s) && (hcnt <= cfg.hs_e);
    de     = (hcnt <= cfg.h_act) && (vcnt <= cfg.v_act);

    half     = ({1'b0, cfg.h_tot} + ONE_H) >> 1;
    shift    = (field && cfg.il) ? half : '0;
    h_ext    = {1'b0, hcnt};
    v_ext    = {1'b0, vcnt};
    on_line  = {1'b0, vss_c} + ONE_V;
    off_line = {1'b0, vse_c} + ONE_V;
    past_on  = (v_ext > on_line)  || ((v_ext == on_line)  && (h_ext >= shift));
    past_off = (v_ext > off_line) || ((v_ext == off_line) && (h_ext >= shift));
    vsync    = past_on && !past_off;

    bad_width   = ({1'b0, cfg.hs_e} < ({1'b0, cfg.hs_s} + MIN_W));
    bad_gap     = ({1'b0, cfg.hs_s} < ({1'b0, cfg.hb_s} + GAP_W));
    bad_size    = (cfg.v_act >= cfg.v_tot);
    bad_parity  = cfg.il && (cfg.v_tot[0] || !cfg.v_act[0]);
    cfg_invalid = bad_width || bad_gap || bad_size || bad_parity;
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          de,
  output logic          frame_start,
  output logic          field,
  output logic          cfg_invalid
);
  rtg_cfg_t cfg_act;
  logic     frame_end;

  rtg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load    (frame_end),
    .cfg_act (cfg_act)
  );

  rtg_counters u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_act),
    .hcnt      (hcnt),
    .vcnt      (vcnt),
    .field     (field),
    .frame_end (frame_end)
  );

  rtg_decode u_dec (
    .cfg         (cfg_act),
    .hcnt        (hcnt),
    .vcnt        (vcnt),
    .field       (field),
    .hsync       (hsync),
    .vsync       (vsync),
    .blank       (blank),
    .de          (de),
    .cfg_invalid (cfg_invalid)
  );

  assign frame_start = (hcnt == '0) && (vcnt == '0);
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic          field,
  input logic          frame_start,
  input rtg_cfg_t      cfg_act
);
  AST_HCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != '0) |-> (hcnt == $past(hcnt) + 1'b1)); // R1
  AST_VCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != '0) |-> $stable(vcnt)); // R1
  AST_VCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((hcnt == '0) && (vcnt != '0)) |-> (vcnt == $past(vcnt) + 1'b1)); // R1
  AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (field != $past(field)) |-> frame_start); // R7
  AST_CFG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start) |-> $stable(cfg_act)); // R10
endmodule

bind raster_timing_gen rtg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hcnt        (hcnt),
  .vcnt        (vcnt),
  .field       (field),
  .frame_start (frame_start),
  .cfg_act     (cfg_act)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] hcnt;
  logic [10:0] vcnt;
  logic        hsync, vsync, blank, de, frame_start, field, cfg_invalid;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 0;
  string tag = "reset";

  // behavioural model state
  int pl[8], ph[8], al[8], ah[8];
  int mh = 0, mv = 0, mf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hcnt(hcnt), .vcnt(vcnt), .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
    .frame_start(frame_start), .field(field), .cfg_invalid(cfg_invalid)
  );

  task automatic chk(string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s [%s] got %0d expected %0d at %0t", what, tag, got, exp, $time);
    end
  endtask

  // model update: reads only bench-driven inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin pl[i] = 0; ph[i] = 0; al[i] = 0; ah[i] = 0; end
      mh = 0; mv = 0; mf = 0;
    end else begin
      bit lend, fend;
      lend = (mh >= ah[0]);
      fend = lend && (mv >= ah[3]);
      if (fend) begin
        mf = (ah[6] != 0) ? 1 - mf : 0;
        for (int i = 0; i < 8; i++) begin al[i] = pl[i]; ah[i] = ph[i]; end  // R10
      end
      if (lend) mv = (mv >= ah_prev_vtot(fend)) ? 0 : mv + 1;
      mh = lend ? 0 : mh + 1;
      if (wr_en) begin  // R11 R12: only field bits are kept
        if (wr_addr <= 2) begin pl[wr_addr] = int'(wr_data[11:0]); ph[wr_addr] = int'(wr_data[27:16]); end
        else if (wr_addr <= 5) begin pl[wr_addr] = int'(wr_data[10:0]); ph[wr_addr] = int'(wr_data[26:16]); end
        else if (wr_addr == 6) begin pl[6] = int'(wr_data[10:0]); ph[6] = int'(wr_data[16]); end
      end
    end
  end

  // line wrap uses the timing that was in force during the ending frame
  int vtot_hold = 0;
  always @(negedge clk) vtot_hold = ah[3];
  function automatic int ah_prev_vtot(bit fend);
    return vtot_hold;
  endfunction

  // compare every output on every clock
  always @(negedge clk) begin
    if (chk_on) begin
      int adj, vbs, vbe, vss, vse, ht, pos, on_p, off_p, sh;
      int e_blank, e_hs, e_vs, e_de, e_fs, e_inv, il;
      il  = ah[6];
      adj = (al[6] > al[3]) ? (al[6] - al[3]) / 2 : 0;  // R8
      vbs = al[4] - adj; vbe = ah[4] - adj; vss = al[5] - adj; vse = ah[5] - adj;
      ht  = ah[0] + 1;
      e_blank = ((mh > al[1] && mh <= ah[1]) || (mv > vbs && mv <= vbe)) ? 1 : 0;
      e_hs    = (mh > al[2] && mh <= ah[2]) ? 1 : 0;
      e_de    = (mh <= al[0] && mv <= al[3]) ? 1 : 0;
      e_fs    = (mh == 0 && mv == 0) ? 1 : 0;
      sh      = (mf == 1 && il == 1) ? ht / 2 : 0;
      pos     = mv * ht + mh;
      on_p    = (vss + 1) * ht + sh;
      off_p   = (vse + 1) * ht + sh;
      e_vs    = (pos >= on_p && pos < off_p) ? 1 : 0;
      e_inv   = (ah[2] < al[2] + 8 || al[2] < al[1] + 8 || al[3] >= ah[3] ||
                 (il == 1 && (ah[3] % 2 == 1 || al[3] % 2 == 0))) ? 1 : 0;
      chk("R1 hcnt", int'(hcnt), mh);
      chk("R1 vcnt", int'(vcnt), mv);
      chk("R2 frame_start", int'(frame_start), e_fs);
      chk("R3 de", int'(de), e_de);
      chk("R4/R8 blank", int'(blank), e_blank);
      chk("R5 hsync", int'(hsync), e_hs);
      chk("R6/R8 vsync", int'(vsync), e_vs);
      chk("R7 field", int'(field), mf);
      chk("R9 cfg_invalid", int'(cfg_invalid), e_inv);
    end
  end

  task automatic wr(int addr, int lo, int hi, logic [31:0] resv);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = addr[2:0];
    wr_data = ((32'(hi) << 16) | 32'(lo)) | resv;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic program_all(int hact, int htot, int hbs, int hbe, int hss, int hse,
                             int vact, int vtot, int vbs, int vbe, int vss, int vse,
                             int pan, int il, bit resv);
    logic [31:0] rh, rv, rp;
    rh = resv ? 32'hF000_F000 : '0;
    rv = resv ? 32'hF800_F800 : '0;
    rp = resv ? 32'hFFFE_F800 : '0;
    wr(0, hact, htot, rh);
    wr(1, hbs, hbe, rh);
    wr(2, hss, hse, rh);
    wr(3, vact, vtot, rv);
    wr(4, vbs, vbe, rv);
    wr(5, vss, vse, rv);
    wr(6, pan, il, rp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 R2: reset state
    chk("R1 reset hcnt", int'(hcnt), 0);
    chk("R1 reset vcnt", int'(vcnt), 0);
    chk("R2 reset frame_start", int'(frame_start), 1);
    chk("R7 reset field", int'(field), 0);
    chk("R5 reset hsync", int'(hsync), 0);
    chk_on = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R11 R12 progressive, reserved bits set";
    program_all(31, 49, 31, 49, 39, 47, 14, 19, 14, 19, 15, 17, 0, 0, 1'b1);
    repeat (3000) @(negedge clk);

    tag = "R10 mid-frame hsync change, R11 address 7";
    repeat (400) @(negedge clk);
    wr(2, 41, 49, 32'h0);
    wr(7, 32'h7FF, 32'h7FF, 32'hFFFF_FFFF);
    repeat (2000) @(negedge clk);

    tag = "R8 centred panel";
    wr(3, 13, 19, 32'h0);
    wr(4, 17, 19, 32'h0);
    wr(5, 18, 19, 32'h0);
    wr(6, 19, 0, 32'h0);
    repeat (2500) @(negedge clk);

    tag = "R7 interlaced";
    program_all(31, 49, 31, 49, 39, 47, 13, 20, 14, 20, 15, 17, 0, 1, 1'b0);
    repeat (4500) @(negedge clk);

    tag = "R9 narrow hsync";
    wr(2, 39, 46, 32'h0);
    repeat (1200) @(negedge clk);

    tag = "R9 odd total in interlace";
    wr(3, 13, 19, 32'h0);
    wr(2, 40, 48, 32'h0);
    repeat (1200) @(negedge clk);

    tag = "R7 back to progressive";
    wr(6, 0, 0, 32'h0);
    repeat (2500) @(negedge clk);

    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog [all] got timeout expected completion");
    finish_run();
  end
endmodule